// File: doc/BRIEF.md
# I2S Slave Audio Receiver with IEC60958 Subframe Builder

This block takes a stereo PCM stream from a host over a three-wire I2S link (bit clock, word select, serial data), in which the host drives both the bit clock and the word select. The three link wires are brought into the system clock domain and their rising bit-clock edges are found there. Each left and right sample is captured at a sample width chosen by configuration. The sample is placed at the top of a 24-bit audio field, and one 32-bit word per channel is handed to a downstream display-link packetizer with a one-cycle valid strobe.

When framing is enabled, each word is an IEC60958-style subframe: a preamble code, the audio field, validity and user bits, one channel-status bit taken from a 192-bit configured status vector, and an even-parity bit. A frame counter that wraps every 192 frames selects the status bit and marks block starts. When framing is disabled, the block passes the aligned sample through unchanged. The logic is clocked only by the system clock, so every audio sample rate from 32 kHz to 192 kHz works with the same structure, provided the bit clock stays at or below one quarter of the system clock.

Top module: `pcmSubframeRx`

## Requirements
- R1: Serial data is sampled on each rising bit-clock edge. The MSB of a word is the bit one bit-clock after a word-select change. Word select low marks a left word and high marks a right word, and `outRight` is 1 for a right word. A word is complete at the next word-select change, and the bit sampled on that change edge still belongs to the finished word.
- R2: `cfgWidth` selects the sample width: 0 gives 16, 1 gives 18, 2 gives 20 and 3 gives 24 bits. Serial bits past the selected width in a word have no effect on the output.
- R3: The sample is left-justified in a 24-bit audio field, with the MSB at field bit 23, and the unused low field bits are zero.
- R4: With `cfgFrameEn` = 0, `outData` is `{8'h00, audio field}`.
- R5: With `cfgFrameEn` = 1, `outData` holds the preamble in [3:0] and the audio field in [27:4] (field bit 23 at bit 27). Bit 28 is validity (0), bit 29 is user (0), bit 30 is the channel-status bit, and bit 31 makes [31:4] even parity.
- R6: The preamble is 4'b0001 for the left subframe of frame 0 of a block, 4'b0010 for every other left subframe, and 4'b0100 for every right subframe. The frame number starts at 0 after reset, advances after each right subframe and wraps from 191 to 0.
- R7: The channel-status bit of both subframes of frame n is `cfgStatus[n]`.
- R8: `outValid` is high for exactly one system-clock cycle per completed subframe. `outData` and `outRight` hold their values until the next subframe.
- R9: `overflow` is set when a subframe completes while the previous one has not yet been accepted through `outAccept`, and it stays set until reset.
- R10: After reset, `outData`, `outValid`, `outRight` and `overflow` are 0. Bits sent before the first word-select change after reset produce no subframe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Asynchronous active-low reset |
| sckIn | input | 1 | I2S bit clock from host |
| wsIn | input | 1 | I2S word select from host (0 = left) |
| sdIn | input | 1 | I2S serial data |
| cfgWidth | input | 2 | Sample width select (16/18/20/24) |
| cfgFrameEn | input | 1 | 1 = build IEC60958 subframes, 0 = raw samples |
| cfgStatus | input | 192 | Channel-status vector, bit n used in frame n |
| outAccept | input | 1 | Downstream takes the current subframe |
| outData | output | 32 | Subframe or aligned sample |
| outValid | output | 1 | One-cycle strobe per completed subframe |
| outRight | output | 1 | 1 = right-channel subframe |
| overflow | output | 1 | Sticky: subframe lost before acceptance |

## Verification
Raw mode is swept over all four widths. The samples are all ones, a pattern with only the MSB and LSB set, and pseudo-random values, each sent as a full 24-bit word. Comparing these against arithmetic masks separates correct truncation and zero fill from off-by-one errors in the bit position or width decode. Framed mode is run for 194 frames with a status vector that is irregular in frame order. This exposes a wrong wrap point, an early or late frame advance, and a status bit drawn from the wrong frame, and the parity and preamble fields are checked on every subframe. An accept-withheld sequence then shows that a single pending subframe does not raise overflow, but a second one does, and that the flag survives later accepted traffic.

// File: rtl/pcmSubframePkg.sv
package pcmSubframePkg;
  localparam int AUDIO_W = 24;
  localparam int POS_W = 5;

  localparam logic [3:0] PRE_BLOCK = 4'b0001;
  localparam logic [3:0] PRE_LEFT  = 4'b0010;
  localparam logic [3:0] PRE_RIGHT = 4'b0100;

  // Strobes passed from the link control to the datapath each system clock.
  typedef struct packed {
    logic             capture;    // rising bit-clock edge: sample sdBit
    logic             clearWord;  // word-select change: start a new word
    logic             wordDone;   // a word finished and must be emitted
    logic             chanRight;  // channel of the word being captured/finished
    logic [POS_W-1:0] bitPos;     // bit index within the current word
  } strobeT;

  function automatic logic [POS_W-1:0] widthBits(input logic [1:0] sel);
    case (sel)
      2'd0:    widthBits = 5'd16;
      2'd1:    widthBits = 5'd18;
      2'd2:    widthBits = 5'd20;
      default: widthBits = 5'd24;
    endcase
  endfunction
endpackage

// File: rtl/i2sSlaveCtrl.sv
module i2sSlaveCtrl
  import pcmSubframePkg::*;
#(
  parameter int SYNC_STAGES = 2,
  parameter int STATUS_LEN  = 192,
  localparam int FW = $clog2(STATUS_LEN)
) (
  input  logic          clk,
  input  logic          rstN,
  input  logic          sckIn,
  input  logic          wsIn,
  input  logic          sdIn,
  output strobeT        strobe,
  output logic          sdBit,
  output logic [FW-1:0] frameIdx
);
  localparam logic [POS_W-1:0] POS_MAX = '1;
  localparam logic [FW-1:0] FRAME_LAST = FW'(STATUS_LEN - 1);

  logic [SYNC_STAGES-1:0] sckSync, wsSync, sdSync;
  logic sckPrev;
  logic wsPrev;
  logic wsKnown;
  logic armed;
  logic [POS_W-1:0] bitCnt;
  logic [FW-1:0] frameCnt;

  logic sckNow, wsNow, rise, change;

  // Multi-stage synchronizers for the three link wires, kept together so
  // data and word select stay aligned with the bit clock.
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      sckSync <= '0;
      wsSync  <= '0;
      sdSync  <= '0;
      sckPrev <= 1'b0;
    end else begin
      sckSync <= {sckSync[SYNC_STAGES-2:0], sckIn};
      wsSync  <= {wsSync[SYNC_STAGES-2:0], wsIn};
      sdSync  <= {sdSync[SYNC_STAGES-2:0], sdIn};
      sckPrev <= sckSync[SYNC_STAGES-1];
    end
  end

  assign sckNow = sckSync[SYNC_STAGES-1];
  assign wsNow  = wsSync[SYNC_STAGES-1];
  assign sdBit  = sdSync[SYNC_STAGES-1];
  assign rise   = sckNow & ~sckPrev;
  assign change = rise & wsKnown & (wsNow != wsPrev);

  always_comb begin
    strobe.capture   = rise;
    strobe.clearWord = change;
    strobe.wordDone  = change & armed;
    strobe.chanRight = wsPrev;
    strobe.bitPos    = bitCnt;
  end

  // Word tracking: the bit sampled on a change edge closes the old word.
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      wsPrev  <= 1'b0;
      wsKnown <= 1'b0;
      armed   <= 1'b0;
      bitCnt  <= '0;
    end else if (rise) begin
      wsKnown <= 1'b1;
      wsPrev  <= wsNow;
      if (change) begin
        armed  <= 1'b1;
        bitCnt <= '0;
      end else if (bitCnt != POS_MAX) begin
        bitCnt <= bitCnt + 1'b1;
      end
    end
  end

  // Block counter: advances after every right subframe, wraps per block.
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      frameCnt <= '0;
    end else if (change && armed && wsPrev) begin
      frameCnt <= (frameCnt == FRAME_LAST) ? '0 : frameCnt + 1'b1;
    end
  end

  assign frameIdx = frameCnt;
endmodule

// File: rtl/subframeAssembler.sv
module subframeAssembler
  import pcmSubframePkg::*;
#(
  parameter int STATUS_LEN = 192,
  parameter int OUT_W      = 32,
  localparam int FW = $clog2(STATUS_LEN)
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  strobeT                strobe,
  input  logic                  sdBit,
  input  logic [FW-1:0]         frameIdx,
  input  logic [1:0]            cfgWidth,
  input  logic                  cfgFrameEn,
  input  logic [STATUS_LEN-1:0] cfgStatus,
  input  logic                  outAccept,
  output logic [OUT_W-1:0]      outData,
  output logic                  outValid,
  output logic                  outRight,
  output logic                  overflow
);
  localparam int PAD_W = OUT_W - AUDIO_W;

  logic [AUDIO_W-1:0] shReg;
  logic [AUDIO_W-1:0] wordNow;
  logic [POS_W-1:0]   slotIdx;
  logic               inWidth;
  logic [3:0]         preCode;
  logic               statusBit;
  logic [OUT_W-2:0]   body;
  logic [OUT_W-1:0]   framed, raw, nextOut;
  logic               pending;

  // Current word including the bit being sampled this cycle.
  always_comb begin
    wordNow = shReg;
    slotIdx = POS_W'(AUDIO_W - 1) - strobe.bitPos;
    inWidth = strobe.bitPos < widthBits(cfgWidth);
    if (strobe.capture && inWidth) begin
      wordNow[slotIdx] = sdBit;
    end
  end

  always_comb begin
    if (strobe.chanRight)        preCode = PRE_RIGHT;
    else if (frameIdx == '0)     preCode = PRE_BLOCK;
    else                         preCode = PRE_LEFT;
    statusBit = cfgStatus[frameIdx];
    body      = {statusBit, 1'b0, 1'b0, wordNow, preCode};
    framed    = {^body[OUT_W-2:4], body};
    raw       = {{PAD_W{1'b0}}, wordNow};
    nextOut   = cfgFrameEn ? framed : raw;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      shReg <= '0;
    end else if (strobe.clearWord) begin
      shReg <= '0;
    end else if (strobe.capture) begin
      shReg <= wordNow;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      outData  <= '0;
      outValid <= 1'b0;
      outRight <= 1'b0;
      pending  <= 1'b0;
      overflow <= 1'b0;
    end else begin
      outValid <= strobe.wordDone;
      if (strobe.wordDone) begin
        outData  <= nextOut;
        outRight <= strobe.chanRight;
        pending  <= 1'b1;
        if (pending && !outAccept) overflow <= 1'b1;
      end else if (outAccept) begin
        pending <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/pcmSubframeRx.sv
module pcmSubframeRx
  import pcmSubframePkg::*;
#(
  parameter int SYNC_STAGES = 2,
  parameter int STATUS_LEN  = 192,
  parameter int OUT_W       = 32,
  localparam int FW = $clog2(STATUS_LEN)
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  logic                  sckIn,
  input  logic                  wsIn,
  input  logic                  sdIn,
  input  logic [1:0]            cfgWidth,
  input  logic                  cfgFrameEn,
  input  logic [STATUS_LEN-1:0] cfgStatus,
  input  logic                  outAccept,
  output logic [OUT_W-1:0]      outData,
  output logic                  outValid,
  output logic                  outRight,
  output logic                  overflow
);
  strobeT        strobe;
  logic          sdBit;
  logic [FW-1:0] frameIdx;

  i2sSlaveCtrl #(.SYNC_STAGES(SYNC_STAGES), .STATUS_LEN(STATUS_LEN)) u_ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .sckIn    (sckIn),
    .wsIn     (wsIn),
    .sdIn     (sdIn),
    .strobe   (strobe),
    .sdBit    (sdBit),
    .frameIdx (frameIdx)
  );

  subframeAssembler #(.STATUS_LEN(STATUS_LEN), .OUT_W(OUT_W)) u_dp (
    .clk        (clk),
    .rstN       (rstN),
    .strobe     (strobe),
    .sdBit      (sdBit),
    .frameIdx   (frameIdx),
    .cfgWidth   (cfgWidth),
    .cfgFrameEn (cfgFrameEn),
    .cfgStatus  (cfgStatus),
    .outAccept  (outAccept),
    .outData    (outData),
    .outValid   (outValid),
    .outRight   (outRight),
    .overflow   (overflow)
  );
endmodule

// File: rtl/pcmSubframeRxChk.sv
module pcmSubframeRxChk (
  input logic        clk,
  input logic        rstN,
  input logic [31:0] outData,
  input logic        outValid,
  input logic        outRight,
  input logic        overflow,
  input logic        cfgFrameEn,
  input logic [1:0]  cfgWidth
);
  AST_VALID_PULSE: assert property (@(posedge clk) disable iff (!rstN)
    outValid |=> !outValid); // R8

  AST_DATA_HELD: assert property (@(posedge clk) disable iff (!rstN)
    (!outValid && $past(rstN)) |-> ($stable(outData) && $stable(outRight))); // R8

  AST_OVF_STICKY: assert property (@(posedge clk) disable iff (!rstN)
    overflow |=> overflow); // R9

  AST_OVF_CAUSE: assert property (@(posedge clk) disable iff (!rstN)
    $rose(overflow) |-> outValid); // R9

  AST_EVEN_PARITY: assert property (@(posedge clk) disable iff (!rstN)
    (outValid && cfgFrameEn) |-> (^outData[31:4] == 1'b0)); // R5

  AST_FIXED_BITS: assert property (@(posedge clk) disable iff (!rstN)
    (outValid && cfgFrameEn) |-> (outData[29:28] == 2'b00)); // R5

  AST_PREAMBLE: assert property (@(posedge clk) disable iff (!rstN)
    (outValid && cfgFrameEn) |-> ($onehot(outData[3:0]) &&
      (outRight == (outData[3:0] == 4'b0100)))); // R6

  AST_ZERO_FILL: assert property (@(posedge clk) disable iff (!rstN)
    (outValid && !cfgFrameEn) |-> ((outData[31:24] == 8'h00) &&
      (cfgWidth != 2'd0 || outData[7:0] == 8'h00))); // R3
endmodule

bind pcmSubframeRx pcmSubframeRxChk u_chk (
  .clk        (clk),
  .rstN       (rstN),
  .outData    (outData),
  .outValid   (outValid),
  .outRight   (outRight),
  .overflow   (overflow),
  .cfgFrameEn (cfgFrameEn),
  .cfgWidth   (cfgWidth)
);

// File: tb/pcmSubframeRx_tb.sv
module pcmSubframeRx_tb;
  logic         clk = 1'b0;
  logic         rstN = 1'b0;
  logic         sckIn = 1'b0, wsIn = 1'b1, sdIn = 1'b0;
  logic [1:0]   cfgWidth = 2'd3;
  logic         cfgFrameEn = 1'b0;
  logic [191:0] cfgStatus;
  logic         outAccept = 1'b0;
  logic [31:0]  outData;
  logic         outValid, outRight, overflow;

  int checks = 0, fails = 0;
  int expCnt = 0, rxCnt = 0, benchFrame = 0;
  logic [31:0] expData [0:511];
  logic        expRight[0:511];
  bit acceptEn = 1'b1;
  bit done = 1'b0;

  always #10 clk = ~clk;

  pcmSubframeRx u_dut (
    .clk(clk), .rstN(rstN), .sckIn(sckIn), .wsIn(wsIn), .sdIn(sdIn),
    .cfgWidth(cfgWidth), .cfgFrameEn(cfgFrameEn), .cfgStatus(cfgStatus),
    .outAccept(outAccept), .outData(outData), .outValid(outValid),
    .outRight(outRight), .overflow(overflow)
  );

  task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic int widthOf(input logic [1:0] sel);
    return (sel == 2'd0) ? 16 : (sel == 2'd1) ? 18 : (sel == 2'd2) ? 20 : 24;
  endfunction

  function automatic logic [31:0] expWord(input logic [23:0] smp, input bit right, input int frame);
    logic [23:0] audio;
    logic [3:0]  pre;
    logic [30:0] body;
    audio = smp & (24'hFFFFFF << (24 - widthOf(cfgWidth)));
    if (!cfgFrameEn) return {8'h00, audio};
    pre  = right ? 4'b0100 : (frame == 0 ? 4'b0001 : 4'b0010);
    body = {cfgStatus[frame], 2'b00, audio, pre};
    return {^body[30:4], body};
  endfunction

  function automatic logic [23:0] sampleOf(input int k);
    case (k % 4)
      0: return 24'hFFFFFF;
      1: return 24'h800001;
      default: return 24'((k * 32'h9E3779B1) >> 5);
    endcase
  endfunction

  task automatic sendSlot(input bit ws, input bit sd);
    @(negedge clk); sckIn = 1'b0; wsIn = ws; sdIn = sd;
    @(negedge clk);
    @(negedge clk); sckIn = 1'b1;
    @(negedge clk);
  endtask

  task automatic sendWord(input logic [23:0] smp, input bit right);
    expData[expCnt]  = expWord(smp, right, benchFrame);
    expRight[expCnt] = right;
    expCnt++;
    if (right) benchFrame = (benchFrame == 191) ? 0 : benchFrame + 1;
    for (int j = 0; j < 32; j++)
      sendSlot((j == 31) ? ~right : right, (j < 24) ? smp[23 - j] : 1'b0);
  endtask

  // Prologue: data before the first word-select change must be dropped (R10).
  task automatic prologue();
    sendSlot(1'b1, 1'b1); sendSlot(1'b1, 1'b1); sendSlot(1'b1, 1'b0);
    sendSlot(1'b0, 1'b1);
  endtask

  task automatic doReset();
    @(negedge clk); rstN = 1'b0; sckIn = 1'b0; wsIn = 1'b1; sdIn = 1'b0;
    expCnt = 0; rxCnt = 0; benchFrame = 0;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
  endtask

  task automatic finishStream(input string tag);
    repeat (20) @(negedge clk);
    check(rxCnt == expCnt, {tag, " R8 subframe count"}, 32'(rxCnt), 32'(expCnt));
    if (expCnt > 0)
      check(outData == expData[expCnt-1], {tag, " R8 data held"}, outData, expData[expCnt-1]);
  endtask

  // Output monitor: compares each subframe and issues the accept.
  always @(negedge clk) begin
    outAccept = 1'b0;
    if (rstN && outValid) begin
      if (rxCnt >= expCnt) begin
        check(1'b0, "R10 unexpected subframe", outData, 32'h0);
      end else begin
        check(outRight == expRight[rxCnt], "R1 channel flag", 32'(outRight), 32'(expRight[rxCnt]));
        if (cfgFrameEn) begin
          check(outData[3:0] == expData[rxCnt][3:0], "R6 preamble", outData, expData[rxCnt]);
          check(outData[27:4] == expData[rxCnt][27:4], "R5 R2 R3 audio field", outData, expData[rxCnt]);
          check(outData[30] == expData[rxCnt][30], "R7 status bit", outData, expData[rxCnt]);
          check(outData[31:28] == expData[rxCnt][31:28], "R5 parity/validity/user", outData, expData[rxCnt]);
        end else begin
          check(outData == expData[rxCnt], "R4 R2 R3 raw sample", outData, expData[rxCnt]);
        end
      end
      rxCnt++;
      outAccept = acceptEn;
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      fails++; checks++;
      $display("FAIL watchdog expired actual=%0d expected=%0d", rxCnt, expCnt);
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    for (int n = 0; n < 192; n++)
      cfgStatus[n] = (n == 0) || (n == 191) || (((n * 5) % 7) == 1);

    doReset();
    check(outValid == 1'b0, "R10 reset valid", 32'(outValid), 32'h0);
    check(outData == 32'h0, "R10 reset data", outData, 32'h0);
    check(overflow == 1'b0, "R10 reset overflow", 32'(overflow), 32'h0);
    check(outRight == 1'b0, "R10 reset channel", 32'(outRight), 32'h0);

    // Raw mode across all widths (R2 R3 R4 R1).
    cfgFrameEn = 1'b0;
    for (int w = 0; w < 4; w++) begin
      cfgWidth = 2'(w);
      doReset();
      prologue();
      for (int k = 0; k < 8; k++) sendWord(sampleOf(k + w), k[0]);
      finishStream("raw");
    end

    // Framed mode, short width: zero fill inside the subframe (R3 R5).
    cfgFrameEn = 1'b1;
    cfgWidth = 2'd0;
    doReset();
    prologue();
    for (int k = 0; k < 6; k++) sendWord(sampleOf(k), k[0]);
    finishStream("framed16");

    // Framed mode over a full block plus wrap (R6 R7).
    cfgWidth = 2'd3;
    doReset();
    prologue();
    for (int k = 0; k < 388; k++) sendWord(sampleOf(k), k[0]);
    finishStream("framed24");

    // Overflow (R9).
    acceptEn = 1'b0;
    cfgWidth = 2'd2;
    doReset();
    prologue();
    sendWord(24'h123456, 1'b0);
    repeat (20) @(negedge clk);
    check(overflow == 1'b0, "R9 single pending no overflow", 32'(overflow), 32'h0);
    sendWord(24'h654321, 1'b1);
    sendWord(24'h0F0F0F, 1'b0);
    repeat (20) @(negedge clk);
    check(overflow == 1'b1, "R9 overflow set", 32'(overflow), 32'h1);
    acceptEn = 1'b1;
    sendWord(24'hABCDEF, 1'b1);
    sendWord(24'h111111, 1'b0);
    sendWord(24'h222222, 1'b1);
    finishStream("ovf");
    check(overflow == 1'b1, "R9 overflow sticky", 32'(overflow), 32'h1);
    doReset();
    check(overflow == 1'b0, "R9 R10 overflow cleared by reset", 32'(overflow), 32'h0);

    done = 1'b1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule